// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two unsigned operands, each 64 bits wide, and adds the 128-bit product into a running total. The total lives in a single 129-bit register: the low 128 bits hold the sum and bit 128 keeps the carry out of the 128-bit addition. The adder and the register form one merged stage, and the register output feeds straight back into the adder.

Each rising clock edge updates the total when `en` is high. A synchronous clear empties the total. An optional saturation mode stops the total from wrapping: when the next sum would not fit in 129 bits, the register pins at all ones. With saturation off, the total wraps modulo 2^129. A parameter chooses how the product is built. It can be one behavioural multiply, or four half-width partial products that are shifted into place and summed. Both forms give the same result.

Top module: `mac_sat_top`

## Requirements
- R1: The product fed to the accumulator equals the unsigned 128-bit product of `a_in` and `b_in`. After a clear followed by one enabled cycle, `acc_out` equals that product.
- R2: When `en` is high and `clr` and `rst` are low, the clock edge loads `acc_out` with the old `acc_out` plus `a_in*b_in`. The new value is visible after that edge and not before.
- R3: When `en`, `clr` and `rst` are all low, `acc_out` keeps its value whatever the operands are.
- R4: When `clr` is high and `rst` is low, the next edge sets `acc_out` to zero, even if `en` is high.
- R5: When `sat_en` is high, an enabled addition whose true sum is 2^129 or more sets `acc_out` to all ones (2^129-1). While `sat_en` stays high, the total never decreases from one edge to the next unless it is cleared.
- R6: When `sat_en` is low, the sum wraps modulo 2^129. Bit 128 of `acc_out` holds the carry out of the low 128 bits.
- R7: A high `rst` is synchronous. It sets `acc_out` to zero at the next edge and has priority over `clr` and `en`.
- R8: When `acc_out` is all ones and `sat_en` is high, a further enabled accumulate leaves `acc_out` at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accumulate enable |
| clr | input | 1 | Synchronous clear of the total |
| sat_en | input | 1 | Saturation mode select |
| a_in | input | 64 | Operand A, unsigned |
| b_in | input | 64 | Operand B, unsigned |
| acc_out | output | 129 | Registered running total |

## Verification
The clocked properties assume that the control inputs are known and held steady around each rising edge. They also assume that `rst` is high from time zero until the first edges have passed. The bench drives every input on the falling edge and raises `rst` before the first clock, so each property sees settled values. Some checks depend on the saturation mode: the no-decrease and pinned-at-ones properties apply only in cycles where `sat_en` is high. The stimulus therefore includes long runs with `sat_en` high and maximum operands, as well as random runs that switch the mode and the clear.

// File: rtl/mac_pkg.sv
package mac_pkg;

    parameter int unsigned MAC_OPW = 64;
    localparam int unsigned MAC_PRODW = 2 * MAC_OPW;
    localparam int unsigned MAC_ACCW = MAC_PRODW + 1;
    localparam int unsigned MAC_HALFW = MAC_OPW / 2;

    typedef logic [MAC_OPW-1:0] opnd_t;
    typedef logic [MAC_PRODW-1:0] prod_t;
    typedef logic [MAC_ACCW-1:0] acc_t;
    typedef logic [MAC_ACCW:0] wide_t;
    typedef logic [2*MAC_HALFW-1:0] part_t;

    typedef struct packed {
        logic en;
        logic clr;
        logic sat;
    } mac_ctl_t;

    function automatic acc_t acc_add(acc_t acc, prod_t p, logic sat);
        wide_t wide;
        wide = {1'b0, acc} + {2'b00, p};
        if (sat && wide[MAC_ACCW]) begin
            return '1;
        end
        return wide[MAC_ACCW-1:0];
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter bit SPLIT_MUL = 1'b1
) (
    input  opnd_t a,
    input  opnd_t b,
    output prod_t prod
);

    generate
        if (SPLIT_MUL) begin : g_split
            logic [MAC_HALFW-1:0] a_h [2];
            logic [MAC_HALFW-1:0] b_h [2];
            part_t pp [2][2];
            prod_t total;

            always_comb begin
                a_h[0] = a[MAC_HALFW-1:0];
                a_h[1] = a[MAC_OPW-1:MAC_HALFW];
                b_h[0] = b[MAC_HALFW-1:0];
                b_h[1] = b[MAC_OPW-1:MAC_HALFW];
                total = '0;
                for (int i = 0; i < 2; i++) begin
                    for (int j = 0; j < 2; j++) begin
                        pp[i][j] = part_t'(a_h[i]) * part_t'(b_h[j]);
                        total = total + (prod_t'(pp[i][j]) << (MAC_HALFW * (i + j)));
                    end
                end
            end
            assign prod = total;
        end else begin : g_flat
            assign prod = prod_t'(a) * prod_t'(b);
        end
    endgenerate

endmodule

// File: rtl/mac_addacc.sv
module mac_addacc
    import mac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mac_ctl_t ctl,
    input  prod_t    prod,
    output acc_t     acc
);

    acc_t acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ctl.clr) begin
            acc_q <= '0;
        end else if (ctl.en) begin
            acc_q <= acc_add(acc_q, prod, ctl.sat);
        end
    end

    assign acc = acc_q;

    // R7: reset empties the total at the next edge
    a_r7_reset_zero: assert property (@(posedge clk)
        rst |=> acc_q == '0);

    // R4: clear wins over enable
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> acc_q == '0);

    // R3: idle cycles keep the total
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !ctl.clr) |=> $stable(acc_q));

    // R5: with saturation on the total never goes down
    a_r5_no_decrease: assert property (@(posedge clk) disable iff (rst)
        (ctl.sat && !ctl.clr) |=> acc_q >= $past(acc_q));

    // R8: a pinned total stays pinned
    a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl.sat && ctl.en && !ctl.clr && acc_q == '1) |=> acc_q == '1);

endmodule

// File: rtl/mac_sat_top.sv
module mac_sat_top
    import mac_pkg::*;
#(
    parameter bit SPLIT_MUL = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                clr,
    input  logic                sat_en,
    input  logic [MAC_OPW-1:0]  a_in,
    input  logic [MAC_OPW-1:0]  b_in,
    output logic [MAC_ACCW-1:0] acc_out
);

    prod_t    prod_w;
    mac_ctl_t ctl_w;
    acc_t     acc_w;

    assign ctl_w = '{en: en, clr: clr, sat: sat_en};

    mac_product #(
        .SPLIT_MUL(SPLIT_MUL)
    ) u_product (
        .a   (a_in),
        .b   (b_in),
        .prod(prod_w)
    );

    // R1: product parity and zero operand behaviour
    a_r1_lsb: assert property (@(posedge clk) disable iff (rst)
        prod_w[0] == (a_in[0] & b_in[0]));
    a_r1_zero: assert property (@(posedge clk) disable iff (rst)
        (a_in == '0 || b_in == '0) |-> prod_w == '0);

    mac_addacc u_addacc (
        .clk (clk),
        .rst (rst),
        .ctl (ctl_w),
        .prod(prod_w),
        .acc (acc_w)
    );

    assign acc_out = acc_w;

endmodule

// File: tb/mac_sat_top_tb.sv
module mac_sat_top_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  OPW = 64;
    localparam int  ACCW = 2 * OPW + 1;
    localparam int  WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic clr = 1'b0;
    logic sat_en = 1'b0;
    logic [OPW-1:0]  a_in = '0;
    logic [OPW-1:0]  b_in = '0;
    logic [ACCW-1:0] acc_out;

    int checks = 0;
    int fails = 0;
    logic [ACCW-1:0] model = '0;

    localparam logic [OPW-1:0]  MAXOP = '1;
    localparam logic [ACCW-1:0] ALL1 = '1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_sat_top dut_i (
        .clk(clk), .rst(rst), .en(en), .clr(clr), .sat_en(sat_en),
        .a_in(a_in), .b_in(b_in), .acc_out(acc_out)
    );

    function automatic string pick_tag(logic r, logic c, logic e, logic s,
                                       logic [ACCW-1:0] m, logic [OPW-1:0] a,
                                       logic [OPW-1:0] b);
        logic [ACCW:0] w;
        w = {1'b0, m} + ({{(ACCW+1-OPW){1'b0}}, a} * {{(ACCW+1-OPW){1'b0}}, b});
        if (r) return "R7";
        if (c) return "R4";
        if (!e) return "R3";
        if (s && m == ALL1) return "R8";
        if (w[ACCW]) return s ? "R5" : "R6";
        return "R2";
    endfunction

    // One cycle: drive at falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(logic r, logic c, logic e, logic s,
                        logic [OPW-1:0] a, logic [OPW-1:0] b, string tag);
        logic [ACCW:0] w;
        rst = r; clr = c; en = e; sat_en = s; a_in = a; b_in = b;
        if (tag == "") tag = pick_tag(r, c, e, s, model, a, b);
        @(posedge clk);
        if (r || c) begin
            model = '0;
        end else if (e) begin
            w = {1'b0, model} + ({{(ACCW+1-OPW){1'b0}}, a} * {{(ACCW+1-OPW){1'b0}}, b});
            if (s && w[ACCW]) model = ALL1;
            else model = w[ACCW-1:0];
        end
        @(negedge clk);
        checks++;
        if (acc_out !== model) begin
            fails++;
            $display("FAIL %s: acc_out=%h expected=%h", tag, acc_out, model);
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R7: reset state
        step(1, 0, 1, 0, 64'd7, 64'd9, "R7");
        step(1, 0, 1, 0, 64'd7, 64'd9, "R7");
        // R2: small accumulations
        step(0, 0, 1, 0, 64'd3, 64'd5, "R2");
        step(0, 0, 1, 0, 64'd11, 64'd13, "R2");
        step(0, 0, 1, 1, 64'h1_0000_0000, 64'h1_0000_0000, "R2");
        // R3: idle with busy operands
        step(0, 0, 0, 0, MAXOP, MAXOP, "R3");
        step(0, 0, 0, 1, 64'hDEAD_BEEF, 64'h1234, "R3");
        // R4: clear wins over enable
        step(0, 1, 1, 0, MAXOP, MAXOP, "R4");
        // R1: single product after clear
        step(0, 0, 1, 0, 64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF, "R1");
        step(0, 1, 0, 0, 64'd0, 64'd0, "R4");
        step(0, 0, 1, 0, MAXOP, MAXOP, "R1");
        // R6: carry into bit 128, then wrap
        step(0, 0, 1, 0, MAXOP, MAXOP, "R6");
        step(0, 0, 1, 0, MAXOP, MAXOP, "R6");
        step(0, 0, 1, 0, MAXOP, MAXOP, "R6");
        // R5 / R8: saturation
        step(0, 1, 0, 1, 64'd0, 64'd0, "R4");
        step(0, 0, 1, 1, MAXOP, MAXOP, "R5");
        step(0, 0, 1, 1, MAXOP, MAXOP, "R5");
        step(0, 0, 1, 1, MAXOP, MAXOP, "R5");
        step(0, 0, 1, 1, MAXOP, MAXOP, "R8");
        step(0, 0, 1, 1, 64'd0, MAXOP, "R8");
        step(0, 0, 1, 1, 64'd1, 64'd1, "R8");
        // R7: reset wins over clear and enable
        step(1, 1, 1, 1, MAXOP, MAXOP, "R7");
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [OPW-1:0] ra, rb;
            int sel;
            sel = int'($urandom_range(0, 3));
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (sel == 0) begin
                ra = MAXOP - OPW'($urandom_range(0, 3));
                rb = MAXOP;
            end
            step(($urandom_range(0, 49) == 0), ($urandom_range(0, 19) == 0),
                 ($urandom_range(0, 3) != 0), (k >= 200) ? 1'b1 : 1'($urandom_range(0, 1)),
                 ra, rb, "");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule